// File: doc/BRIEF.md
# External Interrupt Flag Unit

This block keeps one pending flag for each of four external interrupt pins and turns those flags into request lines for a CPU. An upstream sense stage sends a one-cycle trigger pulse for each pin whose configured edge or change has occurred. For pins in level mode, the sense stage instead sends the current level condition. The block also takes a per-pin level/edge mode bit, per-pin enables, a global interrupt enable, an acknowledge bus from the CPU and a register write port.

A flag goes to zero in three ways. The CPU can acknowledge that pin's vector. Software can write a one to the flag's bit. A flag is also held at zero for as long as its pin is in level mode. In level mode the pin's request line follows the qualified level condition directly, and the flag is not used. The readable register is 8 bits wide, and only the low four bits carry state.

Top module: `eif_flag_unit`

## Requirements
- R1: While reset is asserted, and after it is released, every flag reads zero and every request line is low.
- R2: Register bits 7 to 4 always read zero, and writing ones to them changes nothing.
- R3: In edge mode, a trigger pulse on pin i sets register bit i. The bit is readable from the first clock edge after the pulse.
- R4: In edge mode, request line i is high exactly when flag i, enable i and the global enable are all one.
- R5: An acknowledge with valid high and a 2-bit index i clears flag i at the next edge. The other flags are unchanged.
- R6: A register write clears every flag whose data bit is one. Flags whose data bit is zero are unchanged.
- R7: While pin i is in level mode (mode bit one), bit i reads zero in the same cycle. The stored flag is cleared at the next edge, so it is still zero when the pin returns to edge mode.
- R8: While pin i is in level mode, request line i equals trigger i AND enable i AND the global enable, with no clock delay.
- R9: If a trigger and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| trig_i | input | 4 | Per-pin trigger pulse in edge mode; level condition in level mode |
| level_mode_i | input | 4 | Per-pin mode: 1 selects level, 0 selects edge |
| pin_en_i | input | 4 | Per-pin interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| ack_valid_i | input | 1 | CPU acknowledges a vector this cycle |
| ack_idx_i | input | 2 | Pin number of the acknowledged vector |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; a one clears the matching flag |
| rd_data_o | output | 8 | Flag register read value |
| irq_o | output | 4 | Per-pin request lines to the CPU |

## Verification
Trigger, acknowledge and write effects on the flags are due one clock edge after the cycle in which they are presented. Level-mode masking of the read value and every request line are combinational, so they are due in the same cycle. The bench drives all inputs on a falling edge and lets one rising edge pass. It then drops the pulses on the next falling edge and samples a moment later, so each registered result is read exactly one edge after its cause. For the combinational level-mode request, the bench samples before any rising edge occurs.

// File: rtl/eif_pkg.sv
package eif_pkg;
  localparam int unsigned EIF_REG_W    = 8;
  localparam int unsigned EIF_NUM_PINS = 4;

  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/eif_rst_sync.sv
module eif_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/eif_clear_decode.sv
module eif_clear_decode #(
  parameter int unsigned NUM_PINS = 4,
  localparam int unsigned IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                ack_valid_i,
  input  logic [IDX_W-1:0]    ack_idx_i,
  input  logic                wr_en_i,
  input  logic [NUM_PINS-1:0] wr_ones_i,
  output logic [NUM_PINS-1:0] clr_o
);
  logic [NUM_PINS-1:0] ack_hit;
  logic [NUM_PINS-1:0] wr_hit;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_dec
    always_comb begin
      ack_hit[g] = ack_valid_i && (ack_idx_i == IDX_W'(g));
      wr_hit[g]  = wr_en_i && wr_ones_i[g];
    end
  end

  assign clr_o = ack_hit | wr_hit;

  // R5: an acknowledge names at most one pin
  assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(ack_hit));
  // R6: with no write and no acknowledge no flag may be cleared
  assert_no_spurious_clear_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!wr_en_i && !ack_valid_i) |-> (clr_o == '0));
endmodule

// File: rtl/eif_flag_cell.sv
module eif_flag_cell
  import eif_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ni,
  input  logic   set_i,
  input  logic   clr_i,
  input  sense_e mode_i,
  output logic   flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_we;

  always_comb begin
    flag_d  = flag_q;
    flag_we = 1'b0;
    if (mode_i == SENSE_LEVEL) begin
      flag_d  = 1'b0;
      flag_we = flag_q;
    end else if (set_i) begin
      flag_d  = 1'b1;
      flag_we = !flag_q;
    end else if (clr_i) begin
      flag_d  = 1'b0;
      flag_we = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_we) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R7: level mode leaves the stored flag clear
  assert_level_clears_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == SENSE_LEVEL) |=> !flag_q);
  // R3, R9: an edge-mode trigger always lands, even against a clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == SENSE_EDGE && set_i) |=> flag_q);
  // R5, R6: a clear without a trigger empties the flag
  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == SENSE_EDGE && !set_i && clr_i) |=> !flag_q);
  // R5, R6: an idle flag keeps its value
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == SENSE_EDGE && !set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/eif_req_gate.sv
module eif_req_gate
  import eif_pkg::*;
(
  input  logic   clk,
  input  logic   rst_ni,
  input  logic   flag_i,
  input  logic   cond_i,
  input  sense_e mode_i,
  input  logic   en_i,
  input  logic   gie_i,
  output logic   req_o
);
  logic source;

  always_comb begin
    source = (mode_i == SENSE_LEVEL) ? cond_i : flag_i;
    req_o  = source && en_i && gie_i;
  end

  // R4, R8: a request never leaves without both enables
  assert_req_qualified_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    req_o |-> (en_i && gie_i));
  // R8: in level mode the request cannot come from a stale flag
  assert_level_source_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == SENSE_LEVEL && !cond_i) |-> !req_o);
endmodule

// File: rtl/eif_flag_unit.sv
module eif_flag_unit
  import eif_pkg::*;
#(
  parameter int unsigned NUM_PINS = EIF_NUM_PINS,
  parameter int unsigned REG_W    = EIF_REG_W,
  localparam int unsigned IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] trig_i,
  input  logic [NUM_PINS-1:0] level_mode_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  input  logic                gie_i,
  input  logic                ack_valid_i,
  input  logic [IDX_W-1:0]    ack_idx_i,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    rd_data_o,
  output logic [NUM_PINS-1:0] irq_o
);
  logic                rst_sync_n;
  logic [NUM_PINS-1:0] clr;
  logic [NUM_PINS-1:0] flags;
  logic [NUM_PINS-1:0] visible;
  logic                unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[REG_W-1:NUM_PINS];

  eif_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eif_clear_decode #(.NUM_PINS(NUM_PINS)) u_clear (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .ack_valid_i (ack_valid_i),
    .ack_idx_i   (ack_idx_i),
    .wr_en_i     (wr_en_i),
    .wr_ones_i   (wr_data_i[NUM_PINS-1:0]),
    .clr_o       (clr)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    sense_e mode;
    assign mode = sense_e'(level_mode_i[p]);

    eif_flag_cell u_cell (
      .clk    (clk),
      .rst_ni (rst_sync_n),
      .set_i  (trig_i[p]),
      .clr_i  (clr[p]),
      .mode_i (mode),
      .flag_o (flags[p])
    );

    eif_req_gate u_req (
      .clk    (clk),
      .rst_ni (rst_sync_n),
      .flag_i (flags[p]),
      .cond_i (trig_i[p]),
      .mode_i (mode),
      .en_i   (pin_en_i[p]),
      .gie_i  (gie_i),
      .req_o  (irq_o[p])
    );

    assign visible[p] = flags[p] && (mode == SENSE_EDGE);
  end

  assign rd_data_o = REG_W'(visible);

  // R2: reserved bits never show anything
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data_o[REG_W-1:NUM_PINS] == '0);
  // R7: a level-mode pin never reads as pending
  assert_level_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_data_o[NUM_PINS-1:0] & level_mode_i) == '0);
endmodule

// File: tb/eif_flag_unit_tb.sv
module eif_flag_unit_tb;
  localparam int NP = 4;

  typedef struct packed {
    logic [3:0] trig;
    logic [3:0] lvl;
    logic [3:0] en;
    logic       gie;
    logic       ackv;
    logic [1:0] acki;
    logic       wr;
    logic [7:0] wd;
    logic [7:0] exp_rd;
    logic [3:0] exp_irq;
    int         req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // R3: pin 0 edge trigger sets bit 0
    '{4'b0001, 4'b0000, 4'b1111, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 8'h01, 4'b0001, 3},
    // R3: pins 1 and 2 together
    '{4'b0110, 4'b0000, 4'b1111, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 8'h07, 4'b0111, 3},
    // R4: global enable off masks all requests
    '{4'b0000, 4'b0000, 4'b1111, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'h07, 4'b0000, 4},
    // R4: per-pin enables mask pin 1
    '{4'b0000, 4'b0000, 4'b0101, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 8'h07, 4'b0101, 4},
    // R5: acknowledge pin 1 clears only bit 1
    '{4'b0000, 4'b0000, 4'b1111, 1'b1, 1'b1, 2'd1, 1'b0, 8'h00, 8'h05, 4'b0101, 5},
    // R6 and R2: write F4 clears bit 2, reserved ones ignored
    '{4'b0000, 4'b0000, 4'b1111, 1'b1, 1'b0, 2'd0, 1'b1, 8'hF4, 8'h01, 4'b0001, 6},
    // R6: writing zeros changes nothing
    '{4'b0000, 4'b0000, 4'b1111, 1'b1, 1'b0, 2'd0, 1'b1, 8'h00, 8'h01, 4'b0001, 6},
    // R9: trigger and write-one on pin 3 in one cycle
    '{4'b1000, 4'b0000, 4'b1111, 1'b1, 1'b0, 2'd0, 1'b1, 8'h08, 8'h09, 4'b1001, 9},
    // R9: trigger and acknowledge on pin 0 in one cycle
    '{4'b0001, 4'b0000, 4'b1111, 1'b1, 1'b1, 2'd0, 1'b0, 8'h00, 8'h09, 4'b1001, 9},
    // R7: pin 3 to level mode hides and clears bit 3
    '{4'b0000, 4'b1000, 4'b1111, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 8'h01, 4'b0001, 7},
    // R7: back to edge mode, bit 3 stays clear
    '{4'b0000, 4'b0000, 4'b1111, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00, 8'h01, 4'b0001, 7},
    // R6: clear the last flag
    '{4'b0000, 4'b0000, 4'b1111, 1'b1, 1'b0, 2'd0, 1'b1, 8'h01, 8'h00, 4'b0000, 6}
  };

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] trig_i, level_mode_i, pin_en_i;
  logic          gie_i, ack_valid_i, wr_en_i;
  logic [1:0]    ack_idx_i;
  logic [7:0]    wr_data_i, rd_data_o;
  logic [NP-1:0] irq_o;

  int n_chk;
  int n_bad;

  eif_flag_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .level_mode_i (level_mode_i),
    .pin_en_i     (pin_en_i),
    .gie_i        (gie_i),
    .ack_valid_i  (ack_valid_i),
    .ack_idx_i    (ack_idx_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .irq_o        (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drop_pulses();
    trig_i      = '0;
    ack_valid_i = 1'b0;
    wr_en_i     = 1'b0;
    wr_data_i   = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    drop_pulses();
    level_mode_i = '0;
    pin_en_i     = '0;
    gie_i        = 1'b0;
    ack_idx_i    = '0;
    do_reset();

    // R1: state after reset
    check("R1", "rd after reset", rd_data_o, 8'h00);
    check("R1", "irq after reset", {4'b0, irq_o}, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      trig_i       = VEC[i].trig;
      level_mode_i = VEC[i].lvl;
      pin_en_i     = VEC[i].en;
      gie_i        = VEC[i].gie;
      ack_valid_i  = VEC[i].ackv;
      ack_idx_i    = VEC[i].acki;
      wr_en_i      = VEC[i].wr;
      wr_data_i    = VEC[i].wd;
      @(posedge clk);
      @(negedge clk);
      drop_pulses();
      #1;
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d rd", i),
            rd_data_o, VEC[i].exp_rd);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d irq", i),
            {4'b0, irq_o}, {4'b0, VEC[i].exp_irq});
    end

    // R8: level-mode request follows the condition within the cycle
    @(negedge clk);
    level_mode_i = 4'b0100;
    pin_en_i     = 4'b1111;
    gie_i        = 1'b1;
    trig_i       = 4'b0100;
    #1;
    check("R8", "level irq same cycle", {4'b0, irq_o}, 8'h04);
    gie_i = 1'b0;
    #1;
    check("R8", "level irq gie off", {4'b0, irq_o}, 8'h00);
    gie_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R7: level condition does not show as a flag
    check("R7", "level rd masked", rd_data_o, 8'h00);
    trig_i = 4'b0000;
    #1;
    check("R8", "level irq drops", {4'b0, irq_o}, 8'h00);
    level_mode_i = 4'b0000;
    @(posedge clk);
    @(negedge clk);
    check("R7", "no flag after level", rd_data_o, 8'h00);

    // R1: reset mid-operation clears set flags
    trig_i = 4'b1111;
    @(posedge clk);
    @(negedge clk);
    drop_pulses();
    #1;
    check("R3", "all flags set", rd_data_o, 8'h0F);
    rst_n = 1'b0;
    #1;
    check("R1", "rd during reset", rd_data_o, 8'h00);
    check("R1", "irq during reset", {4'b0, irq_o}, 8'h00);
    do_reset();
    check("R1", "rd after reset release", rd_data_o, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule